// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is an 8-bit timer whose counter runs up from zero to 255 and then back down to zero. On every step it compares the count against a compare value and drives one PWM pin. The result is a pulse that sits symmetrically around the bottom of the count. A full up-and-down period is 510 timer ticks. A clock-select code chooses one of seven divide ratios from a free-running prescaler, or stops the timer.

Software writes a new duty value at any time. The value is held in a staging buffer and takes effect only when the counter turns around at its top. This keeps each period free of glitches. At that turnaround the pin is driven to the level that a rising-slope match would leave. This gives a symmetric edge even when no match happened, for example when the duty leaves full scale, or when the counter passed the compare value before it took effect. Two sticky flags report the bottom turnaround and the compare hits. Software clears each flag by writing a one to it.

Top module: `pcpwm_timer`

## Requirements
- R1: Each tick moves the count one step, from 0 up to 255 and then down to 0, so the count repeats every 510 ticks. Reset leaves the count at 0, rising.
- R2: `clk_sel` picks the tick rate. Code 0 stops the timer. Codes 1 to 7 divide the clock by 1, 8, 32, 64, 128, 256 and 1024. The divider restarts at reset, so the first tick comes on the N-th clock edge after reset.
- R3: `ovf_flag` goes to 1 on the tick that brings the count to 0.
- R4: `cmp_flag` goes to 1 on the tick whose new count equals the active compare value, on either slope. The comparison uses the active value as it was before that tick.
- R5: With `flag_clr_en` high, a 1 in `flag_clr_data` clears a flag: bit 0 clears `ovf_flag` and bit 1 clears `cmp_flag`. A 0 bit leaves its flag unchanged. A set in the same cycle wins over a clear.
- R6: In `out_mode` 2, the pin goes low on a match reached while counting up, and goes high on a match reached while counting down.
- R7: In `out_mode` 3, the pin is the complement of the mode-2 level.
- R8: In `out_mode` 0 or 1, the pin is held at 0.
- R9: A compare write only fills a staging buffer. The active compare value copies the buffer on the tick that brings the count to 255, so the pin keeps its timing until then.
- R10: An active compare value of 0 keeps the mode-2 level low. An active value of 255 keeps the mode-2 level high from the top turnaround at which that value loads.
- R11: On the tick that reaches 255, the mode-2 level becomes low, the rising-slope match level. The exception is a newly loaded value of 255, which makes the level high. This holds whether or not a match occurred.
- R12: After reset, both flags are 0, the buffer and the active compare value are 0, and the mode-2 level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Tick-rate select (0 stops the timer) |
| out_mode | input | 2 | Pin mode: 0/1 off, 2 non-inverted, 3 inverted |
| cmp_wr_en | input | 1 | Write strobe for the compare staging buffer |
| cmp_wr_data | input | 8 | Compare value to write |
| flag_clr_en | input | 1 | Write strobe for flag clearing |
| flag_clr_data | input | 2 | Write-one-to-clear bits: bit 0 overflow, bit 1 compare |
| pwm_out | output | 1 | PWM pin |
| ovf_flag | output | 1 | Sticky bottom-reached flag |
| cmp_flag | output | 1 | Sticky compare-hit flag |

## Verification
The counter itself is not visible at the ports, so a wrong count or a wrong direction shows up first in the flags and in the pin. An error of one step moves the next pin edge by one clock at N=1. A wrong turnaround moves the overflow flag away from its 510-tick rhythm, and this is seen within one period. A value loaded into the active compare register at the wrong time, or a missing forced level at the top, changes the pin within half a period. For that reason the bench compares the pin and both flags on every clock across several whole periods, against a count it derives itself.

// File: rtl/pcpwm_pkg.sv
// Package: shared widths, pin-mode encoding and prescaler decode.
// Assumes: select code 0 means stopped; other codes map to a power-of-two divide.
package pcpwm_pkg;

    localparam int CNT_W = 8;   // counter and compare width
    localparam int PRE_W = 10;  // prescaler width (largest divide is 2**PRE_W)

    typedef enum logic [1:0] {
        OM_OFF_A  = 2'd0,
        OM_OFF_B  = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } om_e;

    // Number of low divider bits that must all be one for a tick.
    function automatic int sel_shift(input logic [2:0] sel);
        case (sel)
            3'd1:    return 0;
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
// Prescaler: a free-running divider that gives single-cycle tick enables.
// Assumes: sel==0 gives no ticks; the divider restarts at reset, so the first
// tick comes on the N-th edge after reset.
module pcpwm_prescaler #(
    parameter int PRE_W = pcpwm_pkg::PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;

    // Free-running divide count.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + ONE;
    end

    // Decode the select code into a low-bit mask and raise the tick when all masked bits are one.
    always_comb begin
        mask = (ONE << pcpwm_pkg::sel_shift(sel)) - ONE;
        tick = (sel != 3'd0) && ((div_q & mask) == mask);
    end
endmodule

// File: rtl/pcpwm_slope_ctr.sv
// Slope counter: counts up to all-ones, then down to zero, one step per tick.
// Assumes: tick is a single-cycle enable; dir_up is the direction of the next step.
module pcpwm_slope_ctr #(
    parameter int W = pcpwm_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic [W-1:0] nxt_cnt,
    output logic         dir_up
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = W'(1);

    // Value the counter takes on the next tick.
    always_comb begin
        nxt_cnt = dir_up ? (cnt + ONE) : (cnt - ONE);
    end

    // Step on tick and turn around at either end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (tick) begin
            cnt <= nxt_cnt;
            if (dir_up && nxt_cnt == TOP)    dir_up <= 1'b0;
            if (!dir_up && nxt_cnt == '0)    dir_up <= 1'b1;
        end
    end
endmodule

// File: rtl/pcpwm_cmp_unit.sv
// Compare unit: staging buffer, active compare value and the non-inverted wave level.
// Assumes: the active value loads at the top; the level is forced to the
// rising-match level there, so edges stay symmetric about the bottom.
module pcpwm_cmp_unit #(
    parameter int W = pcpwm_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] nxt_cnt,
    input  logic         step_up,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] act_cmp,
    output logic         wave_lvl,
    output logic         match_hit,
    output logic         bottom_hit
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] buf_q;
    logic         at_top;

    // Event decode for this tick.
    always_comb begin
        at_top     = tick && (nxt_cnt == TOP);
        match_hit  = tick && (nxt_cnt == act_cmp);
        bottom_hit = tick && (nxt_cnt == '0);
    end

    // Staging buffer written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     buf_q <= '0;
        else if (wr_en) buf_q <= wr_data;
    end

    // Active compare value: copied from the buffer only at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_cmp <= '0;
        else if (at_top) act_cmp <= buf_q;
    end

    // Wave level: forced at the top, cleared on a rising match, set on a falling match (never for zero).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_lvl <= 1'b0;
        end else if (at_top) begin
            wave_lvl <= (buf_q == TOP);
        end else if (match_hit) begin
            if (step_up)              wave_lvl <= 1'b0;
            else if (act_cmp != '0)   wave_lvl <= 1'b1;
        end
    end
endmodule

// File: rtl/pcpwm_flag_bits.sv
// Flag bank: sticky flags, cleared by writing one; a set wins over a clear.
// Assumes: set inputs are single-cycle events.
module pcpwm_flag_bits #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          clr_en,
    input  logic [NF-1:0] clr_bits,
    output logic [NF-1:0] flag_o
);
    for (genvar g = 0; g < NF; g++) begin : g_flag
        // One sticky bit with write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                    flag_o[g] <= 1'b0;
            else if (set_i[g])             flag_o[g] <= 1'b1;
            else if (clr_en && clr_bits[g]) flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/pcpwm_timer.sv
// Top: dual-slope PWM timer. It joins the prescaler, slope counter, compare unit
// and flag bank, and drives the pin according to out_mode.
// Assumes: synchronous active-low reset; out_mode acts on the pin at once.
module pcpwm_timer #(
    parameter int W     = pcpwm_pkg::CNT_W,
    parameter int PRE_W = pcpwm_pkg::PRE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   clk_sel,
    input  logic [1:0]   out_mode,
    input  logic         cmp_wr_en,
    input  logic [W-1:0] cmp_wr_data,
    input  logic         flag_clr_en,
    input  logic [1:0]   flag_clr_data,
    output logic         pwm_out,
    output logic         ovf_flag,
    output logic         cmp_flag
);
    logic         tick;
    logic [W-1:0] cnt;
    logic [W-1:0] nxt_cnt;
    logic         dir_up;
    logic [W-1:0] act_cmp;
    logic         wave_lvl;
    logic         match_hit;
    logic         bottom_hit;
    logic [1:0]   flags;

    pcpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (clk_sel),
        .tick (tick)
    );

    pcpwm_slope_ctr #(.W(W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cnt    (cnt),
        .nxt_cnt(nxt_cnt),
        .dir_up (dir_up)
    );

    pcpwm_cmp_unit #(.W(W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .nxt_cnt   (nxt_cnt),
        .step_up   (dir_up),
        .wr_en     (cmp_wr_en),
        .wr_data   (cmp_wr_data),
        .act_cmp   (act_cmp),
        .wave_lvl  (wave_lvl),
        .match_hit (match_hit),
        .bottom_hit(bottom_hit)
    );

    pcpwm_flag_bits #(.NF(2)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   ({match_hit, bottom_hit}),
        .clr_en  (flag_clr_en),
        .clr_bits(flag_clr_data),
        .flag_o  (flags)
    );

    // Flag outputs: bit 0 overflow, bit 1 compare.
    always_comb begin
        ovf_flag = flags[0];
        cmp_flag = flags[1];
    end

    // Pin mux by mode.
    always_comb begin
        case (pcpwm_pkg::om_e'(out_mode))
            pcpwm_pkg::OM_NONINV: pwm_out = wave_lvl;
            pcpwm_pkg::OM_INV:    pwm_out = ~wave_lvl;
            default:              pwm_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcpwm_checker.sv
// Checker: properties of the dual-slope timer, bound into the top module.
module pcpwm_checker #(
    parameter int W = pcpwm_pkg::CNT_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic         dir_up,
    input logic [W-1:0] act_cmp,
    input logic         wave_lvl,
    input logic [1:0]   out_mode,
    input logic         pwm_out,
    input logic         ovf_flag,
    input logic         cmp_flag
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dir_up) |=> ((cnt - $past(cnt)) == W'(1)));

    a_r1_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dir_up) |=> (($past(cnt) - cnt) == W'(1)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    a_r3_ovf_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (cnt == '0));

    a_r4_cmp_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> (cnt == $past(act_cmp)));

    a_r8_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        !out_mode[1] |-> !pwm_out);

    a_r9_load_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cmp) |-> (cnt == TOP));

    a_r10_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cmp == '0) |-> !wave_lvl);

    a_r10_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cmp == TOP) |-> wave_lvl);

    a_r11_top_force: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == TOP) && ($past(cnt) != TOP)) |-> (wave_lvl == (act_cmp == TOP)));
endmodule

bind pcpwm_timer pcpwm_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt     (cnt),
    .dir_up  (dir_up),
    .act_cmp (act_cmp),
    .wave_lvl(wave_lvl),
    .out_mode(out_mode),
    .pwm_out (pwm_out),
    .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag)
);

// File: tb/tb_pcpwm_timer.sv
`timescale 1ns/1ps
// Directed bench for pcpwm_timer. At divide-by-1 it keeps its own count of
// ticks since reset and derives the expected pin and flags from the requirements.
module tb_pcpwm_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'd1;
    logic [1:0] out_mode = 2'd2;
    logic       cmp_wr_en = 1'b0;
    logic [7:0] cmp_wr_data = 8'd0;
    logic       flag_clr_en = 1'b0;
    logic [1:0] flag_clr_data = 2'd0;
    logic       pwm_out, ovf_flag, cmp_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int       k;
    logic [7:0] buf_m, act_m;
    bit       of_m, cf_m, lvl_m;

    always #4 clk = ~clk;

    pcpwm_timer dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .out_mode(out_mode),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .flag_clr_en(flag_clr_en), .flag_clr_data(flag_clr_data),
        .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    task automatic check_eq(input string tag, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s at k=%0d actual=%0d expected=%0d", tag, k, actual, expected);
        end
    endtask

    function automatic bit exp_pin();
        case (out_mode)
            2'd2:    return lvl_m;
            2'd3:    return ~lvl_m;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_reset(input logic [2:0] sel, input logic [1:0] mode);
        @(negedge clk);
        rst_n = 1'b0; clk_sel = sel; out_mode = mode;
        cmp_wr_en = 1'b0; flag_clr_en = 1'b0; flag_clr_data = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        k = 0; buf_m = 8'd0; act_m = 8'd0; of_m = 0; cf_m = 0; lvl_m = 0;
    endtask

    // One clock at divide-by-1: update the model at the edge, check at the falling edge.
    task automatic step(input string tag);
        int p, c;
        bit down, s_of, s_cf;
        @(posedge clk);
        k++;
        p = k % 510;
        c = (p <= 255) ? p : 510 - p;
        down = (p >= 256) || (p == 0);
        s_cf = (c == act_m);
        s_of = (c == 0);
        of_m = s_of ? 1'b1 : ((flag_clr_en && flag_clr_data[0]) ? 1'b0 : of_m);
        cf_m = s_cf ? 1'b1 : ((flag_clr_en && flag_clr_data[1]) ? 1'b0 : cf_m);
        if (c == 255) act_m = buf_m;
        if (cmp_wr_en) buf_m = cmp_wr_data;
        if (act_m == 8'd0)        lvl_m = 1'b0;
        else if (act_m == 8'd255) lvl_m = 1'b1;
        else                      lvl_m = (c < act_m) || (down && c == act_m);
        @(negedge clk);
        cmp_wr_en = 1'b0; flag_clr_en = 1'b0; flag_clr_data = 2'd0;
        check_eq({tag, " pin"}, pwm_out, exp_pin());
        check_eq("R3 ovf_flag", ovf_flag, of_m);
        check_eq("R4 cmp_flag", cmp_flag, cf_m);
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic write_cmp(input logic [7:0] v, input string tag);
        cmp_wr_en = 1'b1; cmp_wr_data = v;
        step(tag);
    endtask

    task automatic t_reset_state();
        do_reset(3'd1, 2'd2);
        check_eq("R12 pin after reset", pwm_out, 0);
        check_eq("R12 ovf after reset", ovf_flag, 0);
        check_eq("R12 cmp after reset", cmp_flag, 0);
        do_reset(3'd1, 2'd3);
        check_eq("R12 R7 inverted pin after reset", pwm_out, 1);
    endtask

    task automatic t_noninv();
        do_reset(3'd1, 2'd2);
        write_cmp(8'd100, "R6");
        run("R6 R1 R11", 1300);
        do_reset(3'd1, 2'd2);
        write_cmp(8'd1, "R6");
        run("R6 R1", 1100);
    endtask

    task automatic t_inverted();
        do_reset(3'd1, 2'd3);
        write_cmp(8'd60, "R7");
        run("R7", 1100);
    endtask

    task automatic t_disconnected();
        do_reset(3'd1, 2'd0);
        write_cmp(8'd90, "R8");
        run("R8 mode0", 600);
        do_reset(3'd1, 2'd1);
        write_cmp(8'd90, "R8");
        run("R8 mode1", 600);
    endtask

    task automatic t_extremes();
        do_reset(3'd1, 2'd2);
        write_cmp(8'd0, "R10");
        run("R10 zero", 1100);
        do_reset(3'd1, 2'd2);
        write_cmp(8'd255, "R10");
        run("R10 full", 1100);
        do_reset(3'd1, 2'd3);
        write_cmp(8'd255, "R10");
        run("R10 full inverted", 600);
    endtask

    task automatic t_buffer();
        do_reset(3'd1, 2'd2);
        write_cmp(8'd255, "R9");
        run("R9", 400);
        write_cmp(8'd50, "R11");
        run("R11 leave full", 800);
        write_cmp(8'd180, "R9");
        run("R9 mid write", 700);
        write_cmp(8'd20, "R9");
        run("R9 second write", 700);
    endtask

    task automatic t_flags();
        do_reset(3'd1, 2'd2);
        write_cmp(8'd40, "R5");
        run("R5", 599);
        flag_clr_en = 1'b1; flag_clr_data = 2'b00;
        step("R5 zero write");
        check_eq("R5 zero write keeps ovf", ovf_flag, 1);
        flag_clr_en = 1'b1; flag_clr_data = 2'b01;
        step("R5 clear ovf");
        check_eq("R5 ovf cleared", ovf_flag, 0);
        check_eq("R5 cmp kept", cmp_flag, 1);
        flag_clr_en = 1'b1; flag_clr_data = 2'b10;
        step("R5 clear cmp");
        check_eq("R5 cmp cleared", cmp_flag, 0);
        run("R5", 1019 - k);
        flag_clr_en = 1'b1; flag_clr_data = 2'b11;
        step("R5 set wins");
        check_eq("R5 R3 set wins over clear", ovf_flag, 1);
        run("R5", 20);
    endtask

    task automatic t_prescale_one(input logic [2:0] sel, input int n);
        do_reset(sel, 2'd2);
        repeat (510 * n - 1) @(posedge clk);
        @(negedge clk);
        check_eq("R2 R1 ovf not yet", ovf_flag, 0);
        @(posedge clk);
        @(negedge clk);
        check_eq("R2 R1 ovf after 510 ticks", ovf_flag, 1);
    endtask

    task automatic t_prescale();
        t_prescale_one(3'd2, 8);
        t_prescale_one(3'd3, 32);
        do_reset(3'd0, 2'd2);
        repeat (3000) @(posedge clk);
        @(negedge clk);
        check_eq("R2 stopped ovf", ovf_flag, 0);
        check_eq("R2 stopped cmp", cmp_flag, 0);
        check_eq("R2 stopped pin", pwm_out, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        k = 0;
        t_reset_state();
        t_noninv();
        t_inverted();
        t_disconnected();
        t_extremes();
        t_buffer();
        t_flags();
        t_prescale();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule